// File: doc/BRIEF.md
# Six-Pin GPIO Port Configuration Registers

This block holds the control state of a six-pin general-purpose I/O port and makes it available on a byte-wide register bus. Four registers are kept: a per-pin direction register, an analog-select register for the four lowest pins, a per-pin pull-up enable register and an output data latch. From these registers, three static configuration inputs and the global pull-up enable, the block produces registered per-pin drive-enable, drive-value and pull-up-enable signals for the pad ring. A read of the data address returns the digital state of the port.

Pad inputs pass through a two-stage synchronizer before they reach the read path. Analog operation is modelled only as masking of the digital input. The clock-source mode and the reset-pin setting are static inputs. They can force pins to input and they also change what the direction register reads back. Pin 3 can never be driven.

Top module: `gpio_port_cfg`

## Requirements
- R1: After reset the direction register reads 0x3F, every pin is an input and no pin is driven (`pin_oe` = 0, `pin_pu` = 0). Register addresses are 0 data, 1 direction, 2 pull-up enable and 3 analog select. A direction bit of 1 means input and 0 means output. `bus_rdata` shows the register selected by `bus_addr` one clock after the address is presented.
- R2: Pin 3 is input-only. Its direction bit reads 1 whatever is written, and `pin_oe[3]` is never 1.
- R3: With `osc_mode` = 1 (crystal), direction bits 5 and 4 read 1 and pins 5 and 4 are not driven. With `osc_mode` = 2 (RC or external clock), direction bit 5 reads 1 and pin 5 is not driven. With `osc_mode` = 0 or 3 the stored bits apply.
- R4: For an input pin whose analog-select bit is 1, the data read returns 0 in that bit position. For a pin whose direction bit is 0, the analog-select bit has no effect on `pin_oe` or `pin_out`.
- R5: The pull-up enable register resets to 0x37. Bit 3 and bits 7:6 always read 0.
- R6: For pins other than 3, `pin_pu` is 1 only when all four conditions hold: the enable bit is 1, the pin is an input, `pu_global_en` is 1, and the pin is not analog.
- R7: `pin_pu[3]` equals `rst_pin_cfg` and does not depend on any register.
- R8: The analog-select register resets to 0x0F. Bits 7:4 read 0.
- R9: Direction register bits 7:6 read 0.
- R10: A data read returns the synchronized input for input pins and the latch for output pins, with bits 7:6 at 0. A write to the data address updates the latch, which drives `pin_out`.
- R11: A pad input change reaches a data read through a two-flip-flop synchronizer and the read register. It is not visible two clocks after the change and is visible three clocks after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| osc_mode | input | 2 | Clock-source mode: 0 internal, 1 crystal, 2 RC/external, 3 internal |
| rst_pin_cfg | input | 1 | 1 when pin 3 serves as the external reset pin |
| pu_global_en | input | 1 | Global pull-up enable |
| pads_in | input | 6 | Asynchronous pad input values |
| pin_oe | output | 6 | Per-pin drive enable |
| pin_out | output | 6 | Per-pin drive value |
| pin_pu | output | 6 | Per-pin pull-up enable |

## Verification
The bench writes zero to the direction register and checks that pin 3 still reads as an input and is never driven. A design that stored the bit raw would read 0 in that position and enable the drive. It switches clock-source modes with all pins set as outputs. A wrong mode decode would drive a pin that the oscillator owns, or it would hide the stored bit in the internal mode. It enables analog select on both input and output pins: analog must zero the read of an input pin and must leave the driver of an output pin alone. It samples a pad change two and three clocks later, which catches a synchronizer that is missing a stage or has an extra one.

// File: rtl/gpio_cfg_pkg.sv
package gpio_cfg_pkg;
  localparam int N_PINS    = 6;
  localparam int N_ANA     = 4;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 2;
  localparam int RO_PIN    = 3;
  localparam int OSC_PIN_HI = 5;
  localparam int OSC_PIN_LO = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA = 2'd0,
    REG_DIR  = 2'd1,
    REG_PU   = 2'd2,
    REG_ANA  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    CLK_INT  = 2'd0,
    CLK_XTAL = 2'd1,
    CLK_RC   = 2'd2,
    CLK_INT2 = 2'd3
  } clk_src_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain_q[s] <= '0;
        else if (s == 0) chain_q[s] <= din;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [N_PINS-1:0] dir_q,
  output logic [N_PINS-1:0] wpu_q,
  output logic [N_PINS-1:0] lat_q,
  output logic [N_ANA-1:0]  ana_q
);
  localparam logic [N_PINS-1:0] WPU_MASK = ~(N_PINS'(1) << RO_PIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '1;
      wpu_q <= WPU_MASK;
      lat_q <= '0;
      ana_q <= '1;
    end else if (bus_we) begin
      case (reg_sel_e'(bus_addr))
        REG_DATA: lat_q <= bus_wdata[N_PINS-1:0];
        REG_DIR:  dir_q <= bus_wdata[N_PINS-1:0];
        REG_PU:   wpu_q <= bus_wdata[N_PINS-1:0] & WPU_MASK;
        REG_ANA:  ana_q <= bus_wdata[N_ANA-1:0];
        default:  ;
      endcase
    end
  end

  AST_RO_PU_BIT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    bus_we && bus_addr == REG_PU |=> !wpu_q[RO_PIN]); // R5
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
  import gpio_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] dir_q,
  input  logic [N_PINS-1:0] wpu_q,
  input  logic [N_PINS-1:0] lat_q,
  input  logic [N_ANA-1:0]  ana_q,
  input  logic [1:0]        osc_mode,
  input  logic              rst_pin_cfg,
  input  logic              pu_global_en,
  output logic [N_PINS-1:0] dir_eff,
  output logic [N_PINS-1:0] ana_mask,
  output logic [N_PINS-1:0] pin_oe,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_pu
);
  logic [N_PINS-1:0] pu_next;

  always_comb begin
    dir_eff  = dir_q;
    ana_mask = '0;
    ana_mask[N_ANA-1:0] = ana_q;
    dir_eff[RO_PIN] = 1'b1;
    if (clk_src_e'(osc_mode) == CLK_XTAL) begin
      dir_eff[OSC_PIN_HI] = 1'b1;
      dir_eff[OSC_PIN_LO] = 1'b1;
    end else if (clk_src_e'(osc_mode) == CLK_RC) begin
      dir_eff[OSC_PIN_HI] = 1'b1;
    end
  end

  generate
    for (genvar i = 0; i < N_PINS; i++) begin : g_pu
      if (i == RO_PIN) begin : g_ro
        assign pu_next[i] = rst_pin_cfg;
      end else begin : g_rw
        assign pu_next[i] = wpu_q[i] & dir_eff[i] & pu_global_en & ~ana_mask[i];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_oe  <= '0;
      pin_out <= '0;
      pin_pu  <= '0;
    end else begin
      pin_oe  <= ~dir_eff;
      pin_out <= lat_q;
      pin_pu  <= pu_next;
    end
  end

  AST_RO_PIN_NEVER_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    !pin_oe[RO_PIN]); // R2

  AST_OSC_PINS_UNDRIVEN: assert property (@(posedge clk) disable iff (rst)
    $past(osc_mode) == CLK_XTAL |-> !pin_oe[OSC_PIN_HI] && !pin_oe[OSC_PIN_LO]); // R3

  AST_RO_PIN_PU_FOLLOWS_CFG: assert property (@(posedge clk) disable iff (rst)
    pin_pu[RO_PIN] == $past(rst_pin_cfg)); // R7

  generate
    for (genvar j = 0; j < N_PINS; j++) begin : g_chk
      if (j != RO_PIN) begin : g_rw
        AST_PU_NOT_ON_OUTPUT: assert property (@(posedge clk) disable iff (rst)
          pin_pu[j] |-> !pin_oe[j]); // R6
        AST_PU_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (rst)
          pin_pu[j] |-> $past(pu_global_en)); // R6
      end
      if (j < N_ANA && j != RO_PIN) begin : g_ana
        AST_PU_OFF_ANALOG: assert property (@(posedge clk) disable iff (rst)
          pin_pu[j] |-> !$past(ana_q[j])); // R6
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_port_cfg.sv
module gpio_port_cfg
  import gpio_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [1:0]        osc_mode,
  input  logic              rst_pin_cfg,
  input  logic              pu_global_en,
  input  logic [N_PINS-1:0] pads_in,
  output logic [N_PINS-1:0] pin_oe,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_pu
);
  logic [N_PINS-1:0] dir_q, wpu_q, lat_q, dir_eff, ana_mask, pads_sync;
  logic [N_ANA-1:0]  ana_q;
  logic [N_PINS-1:0] port_val;
  logic [DATA_W-1:0] rd_next;

  gpio_in_sync #(.WIDTH(N_PINS), .STAGES(2)) sync_i (
    .clk(clk), .rst(rst), .din(pads_in), .dout(pads_sync)
  );

  gpio_cfg_regs regs_i (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .dir_q(dir_q), .wpu_q(wpu_q), .lat_q(lat_q),
    .ana_q(ana_q)
  );

  gpio_pin_ctrl pins_i (
    .clk(clk), .rst(rst), .dir_q(dir_q), .wpu_q(wpu_q), .lat_q(lat_q),
    .ana_q(ana_q), .osc_mode(osc_mode), .rst_pin_cfg(rst_pin_cfg),
    .pu_global_en(pu_global_en), .dir_eff(dir_eff), .ana_mask(ana_mask),
    .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu)
  );

  // Input pins show the masked pad value, output pins show the latch.
  assign port_val = (dir_eff & pads_sync & ~ana_mask) | (~dir_eff & lat_q);

  always_comb begin
    case (reg_sel_e'(bus_addr))
      REG_DATA: rd_next = DATA_W'(port_val);
      REG_DIR:  rd_next = DATA_W'(dir_eff);
      REG_PU:   rd_next = DATA_W'(wpu_q);
      REG_ANA:  rd_next = DATA_W'(ana_q);
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> pin_oe == '0 && pin_pu == '0); // R1

  AST_DIR_RO_BIT_READS_ONE: assert property (@(posedge clk) disable iff (rst)
    $past(bus_addr) == REG_DIR && !$past(rst) |-> bus_rdata[RO_PIN]); // R2

  AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DATA_W-1:N_PINS] == '0); // R9
endmodule

// File: tb/gpio_port_cfg_tb_top.sv
module gpio_port_cfg_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic [1:0] osc_mode = 2'd0;
  logic       rst_pin_cfg = 1'b0;
  logic       pu_global_en = 1'b0;
  logic [5:0] pads_in = 6'd0;
  logic [5:0] pin_oe, pin_out, pin_pu;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  gpio_port_cfg dut_i (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .osc_mode(osc_mode),
    .rst_pin_cfg(rst_pin_cfg), .pu_global_en(pu_global_en),
    .pads_in(pads_in), .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd1, v); check("R1", "dir after reset", v, 8'h3F);
    check("R1", "oe after reset", {2'b0, pin_oe}, 8'h00);
    check("R1", "pu after reset", {2'b0, pin_pu}, 8'h00);
    rd(2'd2, v); check("R5", "pull-up after reset", v, 8'h37);
    rd(2'd3, v); check("R8", "analog after reset", v, 8'h0F);
    rd(2'd0, v); check("R10", "data after reset", v, 8'h00);
  endtask

  task automatic t_dir();
    logic [7:0] v;
    wr(2'd1, 8'hC0); settle();
    rd(2'd1, v); check("R9", "dir bits 7:6 and pin 3", v, 8'h08);
    check("R2", "pin 3 undriven", {2'b0, pin_oe}, 8'h37);
  endtask

  task automatic t_osc();
    logic [7:0] v;
    wr(2'd1, 8'h00);
    osc_mode = 2'd1; settle();
    rd(2'd1, v); check("R3", "crystal dir read", v, 8'h38);
    check("R3", "crystal oe", {2'b0, pin_oe}, 8'h07);
    osc_mode = 2'd2; settle();
    rd(2'd1, v); check("R3", "rc dir read", v, 8'h28);
    check("R3", "rc oe", {2'b0, pin_oe}, 8'h17);
    osc_mode = 2'd0; settle();
    rd(2'd1, v); check("R3", "internal dir read", v, 8'h08);
  endtask

  task automatic t_data();
    logic [7:0] v;
    wr(2'd3, 8'h00); wr(2'd1, 8'h00); wr(2'd0, 8'h2A);
    pads_in = 6'h00; settle();
    rd(2'd0, v); check("R10", "outputs return latch, pin 3 pad", v, 8'h22);
    check("R10", "pin_out follows latch", {2'b0, pin_out}, 8'h2A);
    pads_in = 6'h08; settle();
    rd(2'd0, v); check("R10", "pin 3 pad high", v, 8'h2A);
    wr(2'd1, 8'hFF); pads_in = 6'h15; settle();
    rd(2'd0, v); check("R10", "inputs return pads", v, 8'h15);
  endtask

  task automatic t_analog();
    logic [7:0] v;
    wr(2'd1, 8'h3F); pads_in = 6'h3F;
    wr(2'd3, 8'h05); settle();
    rd(2'd0, v); check("R4", "analog inputs read 0", v, 8'h3A);
    wr(2'd3, 8'hFF); settle();
    rd(2'd3, v); check("R8", "analog bits 7:4", v, 8'h0F);
    rd(2'd0, v); check("R4", "all analog inputs read 0", v, 8'h30);
    wr(2'd3, 8'h01); wr(2'd1, 8'h3E); wr(2'd0, 8'h01); settle();
    check("R4", "analog output drives", {7'b0, pin_oe[0]}, 8'h01);
    check("R4", "analog output value", {7'b0, pin_out[0]}, 8'h01);
    rd(2'd0, v); check("R4", "analog output reads latch", {7'b0, v[0]}, 8'h01);
  endtask

  task automatic t_pullups();
    logic [7:0] v;
    wr(2'd3, 8'h00); wr(2'd1, 8'h3F); pu_global_en = 1'b1;
    wr(2'd2, 8'hFF); settle();
    rd(2'd2, v); check("R5", "pull-up readback", v, 8'h37);
    check("R6", "all inputs pulled", {2'b0, pin_pu}, 8'h37);
    wr(2'd1, 8'h3C); settle();
    check("R6", "outputs not pulled", {2'b0, pin_pu}, 8'h34);
    pu_global_en = 1'b0; settle();
    check("R6", "global off", {2'b0, pin_pu}, 8'h00);
    pu_global_en = 1'b1; wr(2'd1, 8'h3F); wr(2'd3, 8'h02); settle();
    check("R6", "analog not pulled", {2'b0, pin_pu}, 8'h35);
  endtask

  task automatic t_pin3_pu();
    pu_global_en = 1'b0; rst_pin_cfg = 1'b1; settle();
    check("R7", "reset-pin pull-up on", {2'b0, pin_pu}, 8'h08);
    rst_pin_cfg = 1'b0; settle();
    check("R7", "reset-pin pull-up off", {2'b0, pin_pu}, 8'h00);
  endtask

  task automatic t_sync();
    logic [7:0] v;
    wr(2'd3, 8'h00); wr(2'd1, 8'h3F);
    pads_in = 6'h00;
    @(negedge clk); bus_addr = 2'd0;
    settle();
    pads_in = 6'h02;
    repeat (2) @(negedge clk);
    v = bus_rdata; check("R11", "two clocks after change", v, 8'h00);
    @(negedge clk);
    v = bus_rdata; check("R11", "three clocks after change", v, 8'h02);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_dir();
    t_osc();
    t_data();
    t_analog();
    t_pullups();
    t_pin3_pu();
    t_sync();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule